// File: doc/BRIEF.md
# DVFS Level Transition Sequencer

This block moves a processor clock domain between four performance levels. Level 0 is the fastest at 1000 MHz. Levels 1, 2 and 3 run at 800, 400 and 100 MHz. The block holds the level the domain is running at now. When a new target level is requested, it works out the direction of the move and performs the steps in the order that keeps the core safe:

- **Speeding up:** the two rail voltages are raised before any clock change.
- **Slowing down:** the rail voltages are lowered only after the clocks have settled.

Each step is a request/acknowledge handshake with an outside agent. There are three such agents:

- a voltage interface, which takes one rail and a value in microvolts per request;
- a PLL sequencer, which takes a control word;
- a divider controller, which takes the target level.

A full PLL relock with new M, P and S values is requested only when the move enters or leaves level 0. Every other move asks only for the 3-bit post-divider field to be rewritten.

A request for the level already in use completes at once, with no handshake. While a move is in progress the block shows busy and ignores further requests. It raises done for one cycle when the move ends, and the reported current level takes the new value in that same cycle. Choosing which level to run at is left to the surrounding control logic.

Top module: `dvfs_seq`

## Requirements
- R1: After reset the block is idle: busy, done and all three request lines are low, and the current level reads 3.
- R2: A request whose target equals the current level gives done in the cycle after acceptance, and raises no voltage, PLL or divider request.
- R3: On a move to a lower index (faster), the steps run in this order: core-rail voltage, internal-rail voltage, divider update, PLL change.
- R4: On a move to a higher index (slower), the steps run in this order: PLL change, divider update, core-rail voltage, internal-rail voltage.
- R5: While a voltage request is up, the rail select is 0 for the core rail and 1 for the internal rail. The value is in microvolts for the target level. Core values for levels 0..3 are 1200000, 1100000, 1000000 and 900000. Internal values are 1100000, 1100000, 1000000 and 1000000.
- R6: The full-relock flag is 1 during a PLL request when the target or the origin is level 0, and 0 otherwise (post-divider field only).
- R7: The PLL word carries M in bits [25:16], P in bits [13:8] and S in bits [2:0]. The values are M=250,P=6,S=1 for level 0, M=200,P=6,S=1 for level 1, M=200,P=6,S=2 for level 2 and M=200,P=6,S=4 for level 3.
- R8: Each request line stays high until its acknowledge is sampled high. The next step's request appears in the cycle after that acknowledge.
- R9: Busy is high from the cycle after a request is accepted through the done cycle. Requests that arrive while busy are ignored.
- R10: Done is a single-cycle pulse after the last acknowledge. The current level changes only in that done cycle, where it takes the target.
- R11: While the divider request is up, the divider level output carries the target level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lvl_req_i | input | 1 | Level change request, sampled while idle |
| lvl_tgt_i | input | 2 | Requested target level |
| busy_o | output | 1 | Move in progress |
| done_o | output | 1 | One-cycle end-of-move pulse |
| cur_lvl_o | output | 2 | Level the domain currently runs at |
| vreq_o | output | 1 | Voltage request |
| vrail_o | output | 1 | Rail select, 0 core, 1 internal |
| vuv_o | output | 21 | Requested voltage in microvolts |
| vack_i | input | 1 | Voltage acknowledge |
| pll_req_o | output | 1 | PLL change request |
| pll_full_o | output | 1 | 1 full relock, 0 post-divider only |
| pll_word_o | output | 26 | PLL control word for the target level |
| pll_ack_i | input | 1 | PLL acknowledge |
| div_req_o | output | 1 | Divider update request |
| div_lvl_o | output | 2 | Level for the divider update |
| div_ack_i | input | 1 | Divider acknowledge |

## Verification
A request is taken at the rising edge that samples it. The first step's request line is high from that edge on. Each later step's line rises one edge after the acknowledge that closes the previous step. Done, together with the new current level, follows the edge that samples the last acknowledge, or the edge right after acceptance when the level does not change. Busy drops one edge after done.

The bench keeps a behavioural queue of the pending steps and advances it at the same rising edges. It compares every output against that queue on the falling edge, half a cycle after the registers settle. Acknowledge latencies vary from zero to several cycles, so the timing of each handshake is exercised across those latencies.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
    localparam int NUM_LVL = 4;
    localparam int LVL_W   = $clog2(NUM_LVL);
    localparam int UV_W    = 21;
    localparam int M_W     = 10;
    localparam int P_W     = 6;
    localparam int S_W     = 3;
    localparam int P_LSB   = 8;
    localparam int M_LSB   = 16;
    localparam int WORD_W  = M_LSB + M_W;
    localparam int PLL_P   = 6;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_VCORE,
        ST_VINT,
        ST_DIV,
        ST_PLL,
        ST_DONE
    } step_e;

    typedef struct packed {
        step_e step;
        lvl_t  tgt;
        lvl_t  cur;
        logic  up;
        logic  full;
    } seq_t;

    // Core rail drops by 100 mV per level from 1.2 V.
    function automatic logic [UV_W-1:0] core_uv_of(input int lvl);
        return UV_W'(1200000 - 100000 * lvl);
    endfunction

    // Internal rail is 1.1 V for the two fast levels, 1.0 V below.
    function automatic logic [UV_W-1:0] int_uv_of(input int lvl);
        return UV_W'((lvl < 2) ? 1100000 : 1000000);
    endfunction

    function automatic logic [WORD_W-1:0] pll_word_of(input int lvl);
        logic [WORD_W-1:0] w;
        int m;
        int s;
        m = (lvl == 0) ? 250 : 200;
        s = (lvl == 0) ? 1 : (1 << (lvl - 1));
        w = '0;
        w[M_LSB +: M_W] = M_W'(m);
        w[P_LSB +: P_W] = P_W'(PLL_P);
        w[S_W-1:0]      = S_W'(s);
        return w;
    endfunction
endpackage

// File: rtl/dvfs_level_lut.sv
module dvfs_level_lut
    import dvfs_pkg::*;
#(
    parameter int N = NUM_LVL
) (
    input  lvl_t              lvl_i,
    output logic [UV_W-1:0]   core_uv_o,
    output logic [UV_W-1:0]   int_uv_o,
    output logic [WORD_W-1:0] pll_word_o
);
    logic [UV_W-1:0]   core_tbl [N];
    logic [UV_W-1:0]   int_tbl  [N];
    logic [WORD_W-1:0] word_tbl [N];

    for (genvar g = 0; g < N; g++) begin : g_lvl
        assign core_tbl[g] = core_uv_of(g);
        assign int_tbl[g]  = int_uv_of(g);
        assign word_tbl[g] = pll_word_of(g);
    end

    assign core_uv_o  = core_tbl[lvl_i];
    assign int_uv_o   = int_tbl[lvl_i];
    assign pll_word_o = word_tbl[lvl_i];
endmodule

// File: rtl/dvfs_step_fsm.sv
module dvfs_step_fsm
    import dvfs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  lvl_t tgt_i,
    output logic busy_o,
    output logic done_o,
    output lvl_t cur_o,
    output lvl_t tgt_o,
    output logic vreq_o,
    output logic vrail_o,
    input  logic vack_i,
    output logic pll_req_o,
    output logic pll_full_o,
    input  logic pll_ack_i,
    output logic div_req_o,
    input  logic div_ack_i
);
    localparam lvl_t LVL_SLOW = lvl_t'(NUM_LVL - 1);

    seq_t q, d;

    always_comb begin
        d = q;
        case (q.step)
            ST_IDLE: begin
                if (start_i) begin
                    d.tgt  = tgt_i;
                    d.up   = (tgt_i < q.cur);
                    d.full = (tgt_i == '0) || (q.cur == '0);
                    if (tgt_i == q.cur) d.step = ST_DONE;
                    else if (tgt_i < q.cur) d.step = ST_VCORE;
                    else d.step = ST_PLL;
                end
            end
            ST_VCORE: if (vack_i) d.step = ST_VINT;
            ST_VINT: begin
                if (vack_i) begin
                    if (q.up) d.step = ST_DIV;
                    else begin
                        d.step = ST_DONE;
                        d.cur  = q.tgt;
                    end
                end
            end
            ST_DIV: if (div_ack_i) d.step = q.up ? ST_PLL : ST_VCORE;
            ST_PLL: begin
                if (pll_ack_i) begin
                    if (q.up) begin
                        d.step = ST_DONE;
                        d.cur  = q.tgt;
                    end else d.step = ST_DIV;
                end
            end
            ST_DONE: d.step = ST_IDLE;
            default: d.step = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{step: ST_IDLE, tgt: LVL_SLOW, cur: LVL_SLOW, up: 1'b0, full: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.step != ST_IDLE);
    assign done_o     = (q.step == ST_DONE);
    assign cur_o      = q.cur;
    assign tgt_o      = q.tgt;
    assign vreq_o     = (q.step == ST_VCORE) || (q.step == ST_VINT);
    assign vrail_o    = (q.step == ST_VINT);
    assign pll_req_o  = (q.step == ST_PLL);
    assign pll_full_o = q.full;
    assign div_req_o  = (q.step == ST_DIV);

    p_vhold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        vreq_o && !vack_i |=> vreq_o && $stable(vrail_o));
    p_pll_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pll_req_o && !pll_ack_i |=> pll_req_o);
    p_div_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        div_req_o && !div_ack_i |=> div_req_o);
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_cur_moves_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_o) |-> done_o);
    p_tgt_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && $past(busy_o) |-> $stable(tgt_o));
    p_full_rule_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pll_req_o |-> pll_full_o == ((tgt_o == '0) || (cur_o == '0)));
    p_up_div_after_volt_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(div_req_o) && (tgt_o < cur_o) |-> $past(vreq_o));
    p_dn_volt_after_div_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vreq_o) && (tgt_o > cur_o) |-> $past(div_req_o));
endmodule

// File: rtl/dvfs_seq.sv
module dvfs_seq
    import dvfs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_req_i,
    input  logic [LVL_W-1:0]  lvl_tgt_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [LVL_W-1:0]  cur_lvl_o,
    output logic              vreq_o,
    output logic              vrail_o,
    output logic [UV_W-1:0]   vuv_o,
    input  logic              vack_i,
    output logic              pll_req_o,
    output logic              pll_full_o,
    output logic [WORD_W-1:0] pll_word_o,
    input  logic              pll_ack_i,
    output logic              div_req_o,
    output logic [LVL_W-1:0]  div_lvl_o,
    input  logic              div_ack_i
);
    lvl_t            tgt;
    logic [UV_W-1:0] core_uv;
    logic [UV_W-1:0] int_uv;

    dvfs_step_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (lvl_req_i),
        .tgt_i      (lvl_tgt_i),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .cur_o      (cur_lvl_o),
        .tgt_o      (tgt),
        .vreq_o     (vreq_o),
        .vrail_o    (vrail_o),
        .vack_i     (vack_i),
        .pll_req_o  (pll_req_o),
        .pll_full_o (pll_full_o),
        .pll_ack_i  (pll_ack_i),
        .div_req_o  (div_req_o),
        .div_ack_i  (div_ack_i)
    );

    dvfs_level_lut #(.N(NUM_LVL)) u_lut (
        .lvl_i      (tgt),
        .core_uv_o  (core_uv),
        .int_uv_o   (int_uv),
        .pll_word_o (pll_word_o)
    );

    assign vuv_o     = vrail_o ? int_uv : core_uv;
    assign div_lvl_o = tgt;
endmodule

// File: tb/dvfs_seq_tb.sv
`timescale 1ns/1ps
module dvfs_seq_tb;
    import dvfs_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic              lvl_req = 1'b0;
    logic [LVL_W-1:0]  lvl_tgt = '0;
    logic              vack = 1'b0, pll_ack = 1'b0, div_ack = 1'b0;
    logic              busy, done, vreq, vrail, pll_req, pll_full, div_req;
    logic [LVL_W-1:0]  cur_lvl, div_lvl;
    logic [UV_W-1:0]   vuv;
    logic [WORD_W-1:0] pll_word;

    dvfs_seq u_dut (
        .clk(clk), .rst_n(rst_n), .lvl_req_i(lvl_req), .lvl_tgt_i(lvl_tgt),
        .busy_o(busy), .done_o(done), .cur_lvl_o(cur_lvl),
        .vreq_o(vreq), .vrail_o(vrail), .vuv_o(vuv), .vack_i(vack),
        .pll_req_o(pll_req), .pll_full_o(pll_full), .pll_word_o(pll_word), .pll_ack_i(pll_ack),
        .div_req_o(div_req), .div_lvl_o(div_lvl), .div_ack_i(div_ack)
    );

    int n_chk = 0, n_fail = 0;
    task automatic chk(input string rq, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    // Reference values written from the requirements.
    int core_tab [4] = '{1200000, 1100000, 1000000, 900000};
    int int_tab  [4] = '{1100000, 1100000, 1000000, 1000000};
    int m_tab    [4] = '{250, 200, 200, 200};
    int s_tab    [4] = '{1, 1, 2, 4};
    function automatic longint exp_word(input int l);
        return (longint'(m_tab[l]) << 16) | (longint'(6) << 8) | longint'(s_tab[l]);
    endfunction

    // Behavioural model: queue of pending steps (0 core V, 1 int V, 2 divider, 3 PLL).
    int mq[$];
    bit m_done = 0;
    bit m_a;
    int m_cur = 3, m_tgt = 3;
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete(); m_done = 0; m_cur = 3; m_tgt = 3;
        end else if (m_done) begin
            m_done = 0;
        end else if (mq.size() > 0) begin
            case (mq[0])
                0, 1:    m_a = vack;
                2:       m_a = div_ack;
                default: m_a = pll_ack;
            endcase
            if (m_a) begin
                void'(mq.pop_front());
                if (mq.size() == 0) begin m_done = 1; m_cur = m_tgt; end
            end
        end else if (lvl_req) begin
            m_tgt = int'(lvl_tgt);
            if (m_tgt == m_cur) m_done = 1;
            else if (m_tgt < m_cur) mq = '{0, 1, 2, 3};
            else mq = '{3, 2, 0, 1};
        end
    end

    // Cycle compare, half a cycle after each rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            int h;
            h = (mq.size() > 0) ? mq[0] : -1;
            chk("R9", "busy", busy, (mq.size() > 0) || m_done);
            chk("R10", "done", done, m_done);
            chk("R10", "cur_level", cur_lvl, m_cur);
            chk("R3|R4|R8", "vreq", vreq, (h == 0) || (h == 1));
            chk("R3|R4|R8", "div_req", div_req, h == 2);
            chk("R3|R4|R8", "pll_req", pll_req, h == 3);
            if (vreq) begin
                chk("R5", "vrail", vrail, h == 1);
                chk("R5", "vuv", vuv, (h == 1) ? int_tab[m_tgt] : core_tab[m_tgt]);
            end
            if (pll_req) begin
                chk("R6", "pll_full", pll_full, (m_tgt == 0) || (m_cur == 0));
                chk("R7", "pll_word", pll_word, exp_word(m_tgt));
            end
            if (div_req) chk("R11", "div_lvl", div_lvl, m_tgt);
        end
    end

    // Acknowledge responders with programmable latency.
    int lat_v = 0, lat_p = 0, lat_d = 0;
    int cnt_v = 0, cnt_p = 0, cnt_d = 0;
    always @(negedge clk) begin
        if (vack) begin vack <= 1'b0; cnt_v <= 0; end
        else if (vreq) begin if (cnt_v >= lat_v) vack <= 1'b1; else cnt_v <= cnt_v + 1; end
        if (pll_ack) begin pll_ack <= 1'b0; cnt_p <= 0; end
        else if (pll_req) begin if (cnt_p >= lat_p) pll_ack <= 1'b1; else cnt_p <= cnt_p + 1; end
        if (div_ack) begin div_ack <= 1'b0; cnt_d <= 0; end
        else if (div_req) begin if (cnt_d >= lat_d) div_ack <= 1'b1; else cnt_d <= cnt_d + 1; end
    end

    task automatic wait_done();
        for (int i = 0; i < 400 && !done; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic move(input int lvl);
        @(negedge clk);
        lvl_req = 1'b1;
        lvl_tgt = LVL_W'(lvl);
        @(negedge clk);
        lvl_req = 1'b0;
        wait_done();
        chk("R10", "level after move", cur_lvl, lvl);
        chk("R9", "idle after move", busy, 0);
    endtask

    task automatic move_same(input int lvl);
        @(negedge clk);
        lvl_req = 1'b1;
        lvl_tgt = LVL_W'(lvl);
        @(negedge clk);
        lvl_req = 1'b0;
        chk("R2", "same-level done", done, 1);
        chk("R2", "same-level requests", {vreq, pll_req, div_req}, 0);
        @(negedge clk);
        chk("R2", "same-level level", cur_lvl, lvl);
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset done", done, 0);
        chk("R1", "reset level", cur_lvl, 3);
        chk("R1", "reset requests", {vreq, pll_req, div_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "idle after reset", busy, 0);

        move_same(3);
        move(0);            // up, full relock
        move(1);            // down from L0, full relock
        move(2);            // down, post-divider only
        move(1);            // up, post-divider only
        lat_v = 2; lat_p = 1; lat_d = 3;
        move(3);
        move(0);
        move_same(0);
        move(3);
        lat_v = 3; lat_p = 4; lat_d = 2;
        move(2);

        // Requests while busy must be ignored (R9).
        @(negedge clk);
        lvl_req = 1'b1; lvl_tgt = 2'd0;
        @(negedge clk);
        lvl_tgt = 2'd3;
        repeat (3) @(negedge clk);
        lvl_req = 1'b0;
        wait_done();
        chk("R9", "level after ignored requests", cur_lvl, 0);
        repeat (4) @(negedge clk);
        chk("R9", "no extra move", busy, 0);
        chk("R9", "level held", cur_lvl, 0);

        lat_v = 0; lat_p = 0; lat_d = 0;
        move(2);
        move(3);
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end
endmodule